// File: doc/BRIEF.md
# Tuner Control Serial Slave

This block is the two-wire serial slave of a tuner synthesiser. A host addresses it with a 7-bit device address. The top five address bits are fixed at `11000`, and a 2-bit strap input supplies the two low bits. A write telegram carries data bytes in pairs. The top bit of the first byte of each pair sets its kind: a 15-bit divider ratio, or a set of control bits. Band select, pump current, two test bits, tune disable and three port outputs make up the control bits.

A read telegram returns a status byte. The slave sends it again each time the master acknowledges. The status byte holds a power-on flag, the loop lock flag, two logic-level inputs and a 3-bit level code. The power-on flag is set by reset and by a supply-low event. It clears when a read ends.

Both bus lines are synchronised to the system clock and pass through a spike filter before any decoding. SDA is driven open-drain through an output-enable that pulls the line low.

Top module: `tuner_ctrl_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal `1,1,0,0,0,addr_sel_i[1],addr_sel_i[0]`. Bit 0 of the address byte selects a read (1) or a write (0). After an address that does not match, SDA is not driven until the next start or stop.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Data bits are taken on the SCL rising edge, most significant bit first.
- R3: The slave pulls SDA low during the ninth clock of every matching address byte and of every data byte it receives in a write.
- R4: In a write, a data byte with bit 7 = 0 opens a divider pair. Its bits 6..0 become ratio bits 14..8, and the next byte becomes ratio bits 7..0. `div_ratio_o` updates only once the second byte has arrived.
- R5: A data byte with bit 7 = 1 opens a control pair. In that byte, bit 6 drives `pump_hi_o`, bits 5 and 4 drive `test_o[1]` and `test_o[0]`, and bit 0 drives `tune_off_o`. In the second byte, bit 7 drives `band_uhf_o` and bits 2..0 drive `port_o[2:0]`. The other bits are ignored.
- R6: One telegram may carry a divider pair alone, a control pair alone, or both pairs in either order.
- R7: If a stop or a repeated start arrives after only the first byte of a pair, that byte is dropped and every output register keeps its value.
- R8: A read returns the status byte `{por, lock_i, 0, ttl_i[1], ttl_i[0], level}` (bit 7 down to bit 0). It sends a fresh copy after each master ACK. After a master NACK it releases SDA.
- R9: The level field takes only the values 000 to 100. An input code above 100 is reported as 100.
- R10: The power-on flag is 1 after reset and after any cycle with `supply_low_i` high. It clears when a read telegram ends with a master NACK.
- R11: During reset SDA is not driven. Outside start and stop handling, the SDA drive changes only while SCL is low.
- R12: A pulse on SCL or SDA shorter than `FILT_CYC` clock cycles has no effect on decoding.
- R13: After reset the divider ratio and all control outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When high, pull SDA low |
| addr_sel_i | input | 2 | Strap for the two low address bits |
| supply_low_i | input | 1 | Supply-low event, sets the power-on flag |
| lock_i | input | 1 | Loop lock flag |
| ttl_i | input | 2 | Logic-level port inputs |
| level_i | input | 3 | Level converter code |
| div_ratio_o | output | 15 | Programmed divider ratio |
| band_uhf_o | output | 1 | Band select |
| pump_hi_o | output | 1 | High pump current select |
| test_o | output | 2 | Test mode bits |
| tune_off_o | output | 1 | Tuning output disable |
| port_o | output | 3 | Port output levels |

## Verification
The bench builds the block with its defaults: `FILT_CYC` = 6 and `DIV_W` = 15. Because the filter is six cycles long, a three-cycle SCL pulse can be placed between real clock edges and must leave decoding unchanged. With the 15-bit ratio, every divider bit is set through random pairs. Random telegrams mix pair kinds and orders. Directed telegrams cover the wrong address, half pairs cut off by a stop or a repeated start, out-of-range level codes, and the power-on flag sequence.

// File: rtl/tuner_ctrl_pkg.sv
package tuner_ctrl_pkg;
  localparam logic [4:0] ADDR_PREFIX = 5'b11000;
  localparam int unsigned BYTE_W = 8;
  localparam logic [2:0] LEVEL_MAX = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_IGNORE
  } eng_state_e;
endpackage

// File: rtl/tuner_line_filter.sv
module tuner_line_filter #(
  parameter int unsigned FILT_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  // R12: a new filtered level must equal the synchronised input
  a_r12_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_q[1])));
endmodule

// File: rtl/tuner_i2c_engine.sv
module tuner_i2c_engine
  import tuner_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_f_i,
  input  logic              sda_f_i,
  input  logic [6:0]        dev_addr_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_oe_o,
  output logic              wr_vld_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  output logic              frame_end_o,
  output logic              rd_done_o
);
  eng_state_e        st_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic              sda_oe_q, nack_q, scl_d, sda_d;
  logic              wr_vld_q, frame_end_q, rd_done_q;
  logic              scl_rise, scl_fall, start_w, stop_w;

  assign scl_rise = scl_f_i & ~scl_d;
  assign scl_fall = ~scl_f_i & scl_d;
  assign start_w  = scl_f_i & scl_d & sda_d & ~sda_f_i;
  assign stop_w   = scl_f_i & scl_d & ~sda_d & sda_f_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      sda_oe_q <= 1'b0; nack_q <= 1'b0; scl_d <= 1'b1; sda_d <= 1'b1;
      wr_vld_q <= 1'b0; frame_end_q <= 1'b0; rd_done_q <= 1'b0;
    end else begin
      scl_d       <= scl_f_i;
      sda_d       <= sda_f_i;
      wr_vld_q    <= 1'b0;
      frame_end_q <= 1'b0;
      rd_done_q   <= 1'b0;
      if (start_w) begin
        st_q <= ST_ADDR; cnt_q <= '0; sda_oe_q <= 1'b0; frame_end_q <= 1'b1;
      end else if (stop_w) begin
        st_q <= ST_IDLE; sda_oe_q <= 1'b0; frame_end_q <= 1'b1;
      end else begin
        case (st_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_f_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (st_q == ST_WR) begin
                sda_oe_q <= 1'b1; wr_vld_q <= 1'b1; st_q <= ST_WACK;
              end else if (sh_q[7:1] == dev_addr_i) begin
                sda_oe_q <= 1'b1; st_q <= ST_AACK;
              end else begin
                st_q <= ST_IGNORE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt_q <= '0;
            if (sh_q[0]) begin
              tx_q <= status_i; sda_oe_q <= ~status_i[7]; st_q <= ST_RD;
            end else begin
              sda_oe_q <= 1'b0; st_q <= ST_WR;
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_oe_q <= 1'b0; cnt_q <= '0; st_q <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_oe_q <= 1'b0; st_q <= ST_RACK;
              end else begin
                tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_oe_q <= ~tx_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack_q <= sda_f_i;
            end else if (scl_fall) begin
              if (nack_q) begin
                rd_done_q <= 1'b1; st_q <= ST_IGNORE;
              end else begin
                tx_q <= status_i; sda_oe_q <= ~status_i[7];
                cnt_q <= '0; st_q <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign wr_vld_o    = wr_vld_q;
  assign wr_byte_o   = sh_q;
  assign frame_end_o = frame_end_q;
  assign rd_done_o   = rd_done_q;

  // R11: drive moves only while SCL is low, unless a start or stop just occurred
  a_r11_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sda_oe_q != $past(sda_oe_q)) && !$past(start_w || stop_w)) |-> !$past(scl_f_i));
  // R1: address acknowledge requires a matching address
  a_r1_ack_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_q) && st_q == ST_AACK) |-> ($past(sh_q[7:1]) == dev_addr_i));
  // R8: released after a NACK or a foreign address
  a_r8_ignore_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IGNORE) |-> !sda_oe_q);
endmodule

// File: rtl/tuner_regs.sv
module tuner_regs
  import tuner_ctrl_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              frame_end_i,
  input  logic              rd_done_i,
  input  logic              supply_low_i,
  input  logic              lock_i,
  input  logic [1:0]        ttl_i,
  input  logic [2:0]        level_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              band_o,
  output logic              pump_o,
  output logic [1:0]        test_o,
  output logic              tune_off_o,
  output logic [2:0]        port_o,
  output logic [BYTE_W-1:0] status_o
);
  localparam int unsigned HI_W = DIV_W - BYTE_W;

  logic              pending_q, por_q;
  logic [BYTE_W-1:0] pend_q;
  logic [DIV_W-1:0]  div_q;
  logic              band_q, pump_q, tune_off_q;
  logic [1:0]        test_q;
  logic [2:0]        port_q, level_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0; pend_q <= '0; div_q <= '0;
      band_q <= 1'b0; pump_q <= 1'b0; test_q <= '0;
      tune_off_q <= 1'b0; port_q <= '0;
    end else if (frame_end_i) begin
      pending_q <= 1'b0;
    end else if (wr_vld_i) begin
      if (!pending_q) begin
        pending_q <= 1'b1;
        pend_q    <= wr_byte_i;
      end else begin
        pending_q <= 1'b0;
        if (pend_q[7]) begin
          pump_q     <= pend_q[6];
          test_q     <= pend_q[5:4];
          tune_off_q <= pend_q[0];
          band_q     <= wr_byte_i[7];
          port_q     <= wr_byte_i[2:0];
        end else begin
          div_q <= {pend_q[HI_W-1:0], wr_byte_i};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           por_q <= 1'b1;
    else if (supply_low_i) por_q <= 1'b1;
    else if (rd_done_i)    por_q <= 1'b0;
  end

  assign level_c    = (level_i > LEVEL_MAX) ? LEVEL_MAX : level_i;
  assign status_o   = {por_q, lock_i, 1'b0, ttl_i, level_c};
  assign div_o      = div_q;
  assign band_o     = band_q;
  assign pump_o     = pump_q;
  assign test_o     = test_q;
  assign tune_off_o = tune_off_q;
  assign port_o     = port_q;

  // R10: flag rises only from a supply-low event after reset
  a_r10_por_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(por_q) |-> $past(supply_low_i));
  // R9: reported level never exceeds the top band
  a_r9_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2:0] <= LEVEL_MAX);
  // R7: frame boundary drops a half pair
  a_r7_half_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> !pending_q);
  // R4: ratio moves only on a completing byte
  a_r4_div_on_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q != $past(div_q)) |-> $past(pending_q && wr_vld_i));
endmodule

// File: rtl/tuner_ctrl_slave.sv
module tuner_ctrl_slave
  import tuner_ctrl_pkg::*;
#(
  parameter int unsigned FILT_CYC = 6,
  parameter int unsigned DIV_W    = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [1:0]       addr_sel_i,
  input  logic             supply_low_i,
  input  logic             lock_i,
  input  logic [1:0]       ttl_i,
  input  logic [2:0]       level_i,
  output logic [DIV_W-1:0] div_ratio_o,
  output logic             band_uhf_o,
  output logic             pump_hi_o,
  output logic [1:0]       test_o,
  output logic             tune_off_o,
  output logic [2:0]       port_o
);
  logic [1:0]        raw_w, filt_w;
  logic              wr_vld, frame_end, rd_done;
  logic [BYTE_W-1:0] wr_byte, status;

  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    tuner_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_w[g]),
      .filt_o(filt_w[g])
    );
  end

  tuner_i2c_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_f_i    (filt_w[1]),
    .sda_f_i    (filt_w[0]),
    .dev_addr_i ({ADDR_PREFIX, addr_sel_i}),
    .status_i   (status),
    .sda_oe_o   (sda_oe_o),
    .wr_vld_o   (wr_vld),
    .wr_byte_o  (wr_byte),
    .frame_end_o(frame_end),
    .rd_done_o  (rd_done)
  );

  tuner_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_vld_i    (wr_vld),
    .wr_byte_i   (wr_byte),
    .frame_end_i (frame_end),
    .rd_done_i   (rd_done),
    .supply_low_i(supply_low_i),
    .lock_i      (lock_i),
    .ttl_i       (ttl_i),
    .level_i     (level_i),
    .div_o       (div_ratio_o),
    .band_o      (band_uhf_o),
    .pump_o      (pump_hi_o),
    .test_o      (test_o),
    .tune_off_o  (tune_off_o),
    .port_o      (port_o),
    .status_o    (status)
  );
endmodule

// File: tb/tuner_ctrl_slave_bench.sv
`timescale 1ns/1ps
module tuner_ctrl_slave_bench;
  localparam int Q = 20;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic [1:0] addr_sel = 0;
  logic supply_low = 0, lock = 0;
  logic [1:0] ttl = 0;
  logic [2:0] level = 0;
  logic sda_oe;
  logic [14:0] div_ratio;
  logic band, pump, tune_off;
  logic [1:0] test;
  logic [2:0] port;
  wire sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [14:0] e_div = 0;
  logic e_band = 0, e_pump = 0, e_off = 0, e_por = 1;
  logic [1:0] e_test = 0;
  logic [2:0] e_port = 0;

  always #5 clk = ~clk;

  tuner_ctrl_slave u_tuner_ctrl_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .supply_low_i(supply_low),
    .lock_i(lock), .ttl_i(ttl), .level_i(level), .div_ratio_o(div_ratio),
    .band_uhf_o(band), .pump_hi_o(pump), .test_o(test),
    .tune_off_o(tune_off), .port_o(port)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl_m = 1; wq(Q);
    ack = ~sda_bus;
    wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic get_byte(input logic master_nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1; wq(Q); b[i] = sda_bus; wq(Q); scl_m = 0; wq(Q);
    end
    sda_m = master_nack; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q); sda_m = 1;
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] sel, input logic rd);
    return {5'b11000, sel, rd};
  endfunction

  function automatic logic [7:0] exp_status();
    logic [2:0] lv = (level > 3'd4) ? 3'd4 : level;
    return {e_por, lock, 1'b0, ttl, lv};
  endfunction

  task automatic apply_pair(input logic [7:0] b1, input logic [7:0] b2);
    if (b1[7]) begin
      e_pump = b1[6]; e_test = b1[5:4]; e_off = b1[0];
      e_band = b2[7]; e_port = b2[2:0];
    end else begin
      e_div = {b1[6:0], b2};
    end
  endtask

  task automatic check_regs(input string req);
    check({req, " div"}, 32'(div_ratio), 32'(e_div));
    check({req, " ctrl"}, {24'd0, pump, test, tune_off, band, port},
          {24'd0, e_pump, e_test, e_off, e_band, e_port});
  endtask

  task automatic send_pair(input logic [7:0] b1, input logic [7:0] b2, input string req);
    logic a;
    put_byte(b1, a); check({req, " R3 ack b1"}, 32'(a), 1);
    put_byte(b2, a); check({req, " R3 ack b2"}, 32'(a), 1);
    apply_pair(b1, b2);
  endtask

  task automatic do_read(input int n, input string req);
    logic a;
    logic [7:0] b;
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b1), a);
    check({req, " R1 read addr ack"}, 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i == n - 1, b);
      check({req, " R8 status"}, 32'(b), 32'(exp_status()));
    end
    check({req, " R8 released after NACK"}, 32'(sda_oe), 0);
    e_por = 0;
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d1, d2, c1, c2;
    void'($urandom(32'd1234));
    addr_sel = 2'($urandom);
    wq(5);
    check("R11 no drive in reset", 32'(sda_oe), 0);
    rst_n = 1; wq(5);
    check_regs("R13 reset");

    // status stream and power-on flag clearing
    lock = 1; ttl = 2'b10; level = 3'd2;
    do_read(3, "R10 first read por=1");
    do_read(1, "R10 second read por=0");

    // random telegrams, R4 R5 R6
    for (int t = 0; t < 14; t++) begin
      int kind = int'($urandom % 4);
      d1 = {1'b0, 7'($urandom)}; d2 = 8'($urandom);
      c1 = {1'b1, 7'($urandom)}; c2 = 8'($urandom);
      bus_start();
      put_byte(addr_byte(addr_sel, 1'b0), a);
      check("R1 R3 write addr ack", 32'(a), 1);
      case (kind)
        0: send_pair(d1, d2, "R4");
        1: send_pair(c1, c2, "R5");
        2: begin send_pair(d1, d2, "R6"); send_pair(c1, c2, "R6"); end
        default: begin send_pair(c1, c2, "R6"); send_pair(d1, d2, "R6"); end
      endcase
      bus_stop();
      check_regs("R4 R5 R6 random");
    end

    // foreign address: no ack, registers untouched (R1)
    bus_start();
    put_byte(addr_byte(addr_sel ^ 2'b01, 1'b0), a);
    check("R1 foreign addr no ack", 32'(a), 0);
    put_byte(8'h12, a); put_byte(8'h34, a);
    check("R1 foreign data no ack", 32'(a), 0);
    bus_stop();
    check_regs("R1 foreign write");

    // half pair then stop (R7)
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), a);
    put_byte(8'h55, a);
    bus_stop();
    check_regs("R7 half pair stop");

    // half control pair, repeated start, then divider pair (R7, R2)
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), a);
    put_byte(8'hF1, a);
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), a);
    check("R2 repeated start addr ack", 32'(a), 1);
    send_pair(8'h6A, 8'hC3, "R7");
    bus_stop();
    check_regs("R7 half pair restart");
    check("R4 boundary div", 32'(div_ratio), 32'h6AC3);

    // SCL spike after start must not add a bit (R12)
    bus_start();
    scl_m = 1; wq(3); scl_m = 0; wq(Q);
    put_byte(addr_byte(addr_sel, 1'b0), a);
    check("R12 spike addr ack", 32'(a), 1);
    send_pair(8'h7F, 8'hFF, "R12");
    bus_stop();
    check("R12 div after spike", 32'(div_ratio), 32'h7FFF);

    // level clamp (R9)
    level = 3'd6; lock = 0; ttl = 2'b01;
    do_read(2, "R9 clamp 110");
    level = 3'd7;
    do_read(1, "R9 clamp 111");
    level = 3'd3;
    do_read(1, "R9 in range 011");

    // supply-low sets the flag again (R10)
    @(negedge clk) supply_low = 1;
    @(negedge clk) supply_low = 0;
    e_por = 1;
    do_read(2, "R10 supply low");
    do_read(1, "R10 cleared again");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule